// File: doc/BRIEF.md
# Table-Driven Packet Header Parser

This block takes a packet as a stream of 64-bit chunks and walks its header stack under the control of a parse graph held in configuration registers. Each state of the graph says how long its header is and where the 16-bit next-protocol field sits inside it. It also gives up to four (key, next state) pairs. The walk always begins in state 0 at byte 0 of the packet. For example, state 0 can describe an Ethernet header whose type field leads to a VLAN state or an IPv4 state.

While the walk runs, configured field descriptors copy 32-bit words out of the headers they name into slots of a flat packet header vector (PHV). The PHV also carries a bitmap of the states whose headers were fully parsed and the packet's byte count. The first 64 bytes of each packet are kept in a byte window, so a header that straddles a chunk boundary is read as if it were aligned. The PHV is presented with a valid/ready handshake. No new packet is accepted until the current PHV has been taken.

Top module: `hp_parser`

## Requirements
- R1: After reset `in_ready` is 1 and `phv_valid` is 0, and every parse-graph state has header length 0.
- R2: The input data is big-endian: byte 0 of a chunk is `in_data[63:56]`. A chunk with `in_eop`=1 carries `in_nbytes` valid bytes, where values 1..7 are taken as given and 0 or any value above 8 means 8. A chunk offered while no packet is open and without `in_sop` is discarded and produces no PHV.
- R3: The walk starts in state 0 at offset 0. The key is the 16-bit big-endian value at byte `koff` of the current header. The next state is the one given by the lowest-numbered enabled pair whose key matches. The next header starts `hlen` bytes after the current one. If no pair matches, the walk ends after the current header.
- R4: Field slot i receives the 4 bytes at offset `off` of the header parsed in state `st`, taken from its descriptor, with the first byte in the most significant position. A slot whose descriptor is disabled, or whose state is not visited, reads 0. A state visited twice leaves the later value.
- R5: Bit s of the present bitmap is set only when a header of state s was fully received and parsed. The walk ends without marking a header in three cases: its length is 0, it ends past byte 64 of the packet, or it is cut off by end of packet.
- R6: The length slot holds the number of bytes accepted from the start chunk through the end chunk.
- R7: `phv_valid` rises only after the end chunk has been accepted and the walk has finished. The PHV is held unchanged until `phv_ready` is sampled high, and `phv_valid` then drops.
- R8: `in_ready` is 0 from acceptance of an end chunk until the PHV is taken, so a chunk offered in that time is not consumed.
- R9: Headers that straddle chunk boundaries yield the same bitmap and field values as aligned ones.
- R10: When `cfg_we` is high, `cfg_tbl`=0 writes `cfg_wdata` into the graph state `cfg_addr`. The graph layout is [91:86] hlen, [85:80] koff, and pair p at [20p+19:20p], where a pair is {en, next[2:0], key[15:0]}. `cfg_tbl`=1 writes descriptor `cfg_addr` from [9:0] = {en, st[2:0], off[5:0]}.
- R11: The PHV layout is length in [15:0], the present bitmap in [23:16], and slot i in [24+32i+31:24+32i]. With the reset table, a packet yields only its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Chunk offered |
| in_ready | output | 1 | Chunk can be accepted |
| in_data | input | 64 | Chunk bytes, byte 0 in the top bits |
| in_sop | input | 1 | First chunk of a packet |
| in_eop | input | 1 | Last chunk of a packet |
| in_nbytes | input | 4 | Valid bytes in the last chunk (0 means 8) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 1 | 0 selects the parse graph, 1 the field descriptors |
| cfg_addr | input | 3 | State or descriptor index |
| cfg_wdata | input | 92 | Entry to write |
| phv_valid | output | 1 | PHV available |
| phv_ready | input | 1 | PHV taken |
| phv_data | output | 280 | Slots, present bitmap and length |

## Verification
The case that needs care is a PHV stalled under backpressure while the next packet's start chunk is already offered. Holding the vector and refusing input are then two separate duties in the same cycle. The bench raises `in_valid` with a start chunk for a random number of cycles while `phv_ready` is low. It expects `in_ready` to stay 0 and the vector to stay unchanged, and the next packet's results show that the offered chunk was never consumed. A second overlap is the end chunk arriving in the same cycle that the walk completes its last header. Random packet lengths make this happen often, and the bitmap and length are judged against a bench model of the walk.

// File: rtl/hp_pkg.sv
// Shared types for the header parser: parse-graph node, match pair and
// field descriptor. Assumes at most 8 graph states and 6-bit byte offsets.
package hp_pkg;
    localparam int ST_W   = 3;
    localparam int N_ST   = 1 << ST_W;
    localparam int N_PAIR = 4;
    localparam int KEY_W  = 16;
    localparam int OFF_W  = 6;
    localparam int SLOT_W = 32;

    typedef struct packed {
        logic             en;
        logic [ST_W-1:0]  nxt;
        logic [KEY_W-1:0] key;
    } hp_pair_t;

    typedef struct packed {
        logic [OFF_W-1:0]        hlen;
        logic [OFF_W-1:0]        koff;
        hp_pair_t [N_PAIR-1:0]   pairs;
    } hp_node_t;

    typedef struct packed {
        logic             en;
        logic [ST_W-1:0]  st;
        logic [OFF_W-1:0] off;
    } hp_fdesc_t;

    localparam int NODE_W  = $bits(hp_node_t);
    localparam int FDESC_W = $bits(hp_fdesc_t);
endpackage

// File: rtl/hp_cfg_store.sv
// Configuration storage: parse-graph nodes and field descriptors in flops.
// Assumes writes are single-cycle strobes; all entries reset to zero.
module hp_cfg_store
    import hp_pkg::*;
#(
    parameter int N_FIELDS = 8,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [NODE_W-1:0] cfg_wdata,
    output hp_node_t          nodes [N_ST],
    output hp_fdesc_t         fdesc [N_FIELDS]
);
    genvar s, f;
    generate
        for (s = 0; s < N_ST; s++) begin : g_node
            // Write one graph state when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    nodes[s] <= '0;
                else if (cfg_we && !cfg_tbl && cfg_addr == ADDR_W'(s))
                    nodes[s] <= hp_node_t'(cfg_wdata);
            end
        end
        for (f = 0; f < N_FIELDS; f++) begin : g_fld
            // Write one field descriptor when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fdesc[f] <= '0;
                else if (cfg_we && cfg_tbl && cfg_addr == ADDR_W'(f))
                    fdesc[f] <= hp_fdesc_t'(cfg_wdata[FDESC_W-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/hp_chunk_window.sv
// Chunk capture: stores the first WIN_BYTES bytes of a packet in a byte
// window, counts total bytes and flags end of packet. Assumes every chunk
// but the last is full and WIN_BYTES is a multiple of CHUNK_BYTES.
module hp_chunk_window #(
    parameter int CHUNK_BYTES = 8,
    parameter int WIN_BYTES   = 64,
    parameter int LEN_W       = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               take,
    input  logic                               sop,
    input  logic                               eop,
    input  logic [CHUNK_BYTES*8-1:0]           data,
    input  logic [$clog2(CHUNK_BYTES+1)-1:0]   nbytes,
    input  logic                               clear,
    output logic [7:0]                         win [WIN_BYTES],
    output logic [$clog2(WIN_BYTES+1)-1:0]     rcvd,
    output logic [LEN_W-1:0]                   total_len,
    output logic                               eop_seen
);
    localparam int WIN_CHUNKS = WIN_BYTES / CHUNK_BYTES;
    localparam int CIDX_W     = $clog2(WIN_CHUNKS + 1);
    localparam int CNT_W      = $clog2(CHUNK_BYTES + 1);
    localparam int RC_W       = $clog2(WIN_BYTES + 1);

    logic              pkt_open;
    logic [CIDX_W-1:0] chunk_idx;
    logic              open_take;
    logic [CNT_W-1:0]  last_cnt;
    logic [LEN_W-1:0]  base_len;
    logic [CIDX_W-1:0] base_idx;

    // Decode how many bytes this chunk adds and where it lands.
    always_comb begin
        open_take = take && (sop || pkt_open);
        if (!eop || nbytes == '0 || nbytes > CNT_W'(CHUNK_BYTES))
            last_cnt = CNT_W'(CHUNK_BYTES);
        else
            last_cnt = nbytes;
        base_len = sop ? '0 : total_len;
        base_idx = sop ? '0 : chunk_idx;
    end

    // Track packet state, byte count and chunk index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_open  <= 1'b0;
            eop_seen  <= 1'b0;
            total_len <= '0;
            chunk_idx <= '0;
        end else if (clear) begin
            pkt_open <= 1'b0;
            eop_seen <= 1'b0;
        end else if (open_take) begin
            total_len <= base_len + LEN_W'(last_cnt);
            chunk_idx <= (base_idx == CIDX_W'(WIN_CHUNKS)) ? base_idx : base_idx + 1'b1;
            pkt_open  <= !eop;
            eop_seen  <= eop;
        end
    end

    // Store chunk bytes into their window slot; data needs no reset.
    always_ff @(posedge clk) begin
        for (int c = 0; c < WIN_CHUNKS; c++) begin
            if (open_take && base_idx == CIDX_W'(c)) begin
                for (int b = 0; b < CHUNK_BYTES; b++)
                    win[c*CHUNK_BYTES + b] <= data[(CHUNK_BYTES-1-b)*8 +: 8];
            end
        end
    end

    assign rcvd = (total_len >= LEN_W'(WIN_BYTES)) ? RC_W'(WIN_BYTES) : RC_W'(total_len);
endmodule

// File: rtl/hp_walker.sv
// Parse-graph walker: one header per cycle once its bytes are in the
// window. Marks present states, extracts field words, follows next-state
// pairs. Assumes field and key offsets lie inside their header.
module hp_walker
    import hp_pkg::*;
#(
    parameter int WIN_BYTES = 64,
    parameter int N_FIELDS  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  hp_node_t                        nodes [N_ST],
    input  hp_fdesc_t                       fdesc [N_FIELDS],
    input  logic [7:0]                      win [WIN_BYTES],
    input  logic [$clog2(WIN_BYTES+1)-1:0]  rcvd,
    input  logic                            eop_seen,
    output logic                            busy,
    output logic [N_ST-1:0]                 present,
    output logic [SLOT_W-1:0]               fields [N_FIELDS]
);
    localparam int IDX_W = $clog2(WIN_BYTES);
    localparam int POS_W = $clog2(WIN_BYTES + (1 << OFF_W));

    logic [ST_W-1:0]   cur_st;
    logic [POS_W-1:0]  cur_off;
    hp_node_t          node;
    logic [POS_W-1:0]  end_off;
    logic              fits, have, hit, step, stop;
    logic [ST_W-1:0]   nxt;
    logic [KEY_W-1:0]  key;
    logic [SLOT_W-1:0] fval [N_FIELDS];
    logic [N_FIELDS-1:0] fsel;

    // Read one window byte; positions past the window read zero.
    function automatic logic [7:0] byte_at(input logic [POS_W-1:0] p);
        return (p < POS_W'(WIN_BYTES)) ? win[p[IDX_W-1:0]] : 8'h00;
    endfunction

    // Evaluate the current header: completeness, key match, field words.
    always_comb begin
        node    = nodes[cur_st];
        end_off = cur_off + POS_W'(node.hlen);
        fits    = end_off <= POS_W'(WIN_BYTES);
        have    = end_off <= POS_W'(rcvd);
        key     = {byte_at(cur_off + POS_W'(node.koff)),
                   byte_at(cur_off + POS_W'(node.koff) + 1'b1)};
        hit = 1'b0;
        nxt = '0;
        for (int p = N_PAIR-1; p >= 0; p--) begin
            if (node.pairs[p].en && node.pairs[p].key == key) begin
                hit = 1'b1;
                nxt = node.pairs[p].nxt;
            end
        end
        for (int i = 0; i < N_FIELDS; i++) begin
            fsel[i] = fdesc[i].en && fdesc[i].st == cur_st;
            for (int b = 0; b < 4; b++)
                fval[i][(3-b)*8 +: 8] = byte_at(cur_off + POS_W'(fdesc[i].off) + POS_W'(b));
        end
        step = busy && node.hlen != '0 && fits && have;
        stop = busy && (node.hlen == '0 || !fits || (!have && eop_seen));
    end

    // Advance the walk and record results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_st  <= '0;
            cur_off <= '0;
            present <= '0;
            for (int i = 0; i < N_FIELDS; i++) fields[i] <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cur_st  <= '0;
            cur_off <= '0;
            present <= '0;
            for (int i = 0; i < N_FIELDS; i++) fields[i] <= '0;
        end else if (step) begin
            present[cur_st] <= 1'b1;
            for (int i = 0; i < N_FIELDS; i++)
                if (fsel[i]) fields[i] <= fval[i];
            if (hit) begin
                cur_st  <= nxt;
                cur_off <= end_off;
            end else begin
                busy <= 1'b0;
            end
        end else if (stop) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/hp_parser.sv
// Top of the header parser: accepts chunks, runs the walker, presents the
// PHV with valid/ready. Assumes one packet in flight; input is refused
// from end of packet until the PHV is taken.
module hp_parser
    import hp_pkg::*;
#(
    parameter int CHUNK_BYTES = 8,
    parameter int WIN_BYTES   = 64,
    parameter int N_FIELDS    = 8,
    parameter int LEN_W       = 16,
    localparam int DATA_W = CHUNK_BYTES * 8,
    localparam int CNT_W  = $clog2(CHUNK_BYTES + 1),
    localparam int FIDX_W = $clog2(N_FIELDS),
    localparam int ADDR_W = (FIDX_W > ST_W) ? FIDX_W : ST_W,
    localparam int PHV_W  = N_FIELDS * SLOT_W + N_ST + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [CNT_W-1:0]  in_nbytes,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [NODE_W-1:0] cfg_wdata,
    output logic              phv_valid,
    input  logic              phv_ready,
    output logic [PHV_W-1:0]  phv_data
);
    localparam int RC_W = $clog2(WIN_BYTES + 1);

    hp_node_t          nodes [N_ST];
    hp_fdesc_t         fdesc [N_FIELDS];
    logic [7:0]        win [WIN_BYTES];
    logic [RC_W-1:0]   rcvd;
    logic [LEN_W-1:0]  total_len;
    logic              eop_seen, busy, take, start, taken;
    logic [N_ST-1:0]   present;
    logic [SLOT_W-1:0] fields [N_FIELDS];

    assign in_ready = !eop_seen && !phv_valid;
    assign take     = in_valid && in_ready;
    assign start    = take && in_sop;
    assign taken    = phv_valid && phv_ready;

    hp_cfg_store #(.N_FIELDS(N_FIELDS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .nodes(nodes), .fdesc(fdesc)
    );

    hp_chunk_window #(.CHUNK_BYTES(CHUNK_BYTES), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop), .eop(in_eop),
        .data(in_data), .nbytes(in_nbytes), .clear(taken), .win(win),
        .rcvd(rcvd), .total_len(total_len), .eop_seen(eop_seen)
    );

    hp_walker #(.WIN_BYTES(WIN_BYTES), .N_FIELDS(N_FIELDS)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .nodes(nodes), .fdesc(fdesc),
        .win(win), .rcvd(rcvd), .eop_seen(eop_seen), .busy(busy),
        .present(present), .fields(fields)
    );

    // Raise the PHV once the packet has ended and the walk is over.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phv_valid <= 1'b0;
        else if (taken)
            phv_valid <= 1'b0;
        else if (eop_seen && !busy)
            phv_valid <= 1'b1;
    end

    // Pack the reserved slots and the field slots into the PHV.
    assign phv_data[LEN_W-1:0]           = total_len;
    assign phv_data[LEN_W +: N_ST]       = present;
    genvar i;
    generate
        for (i = 0; i < N_FIELDS; i++) begin : g_slot
            assign phv_data[LEN_W + N_ST + SLOT_W*i +: SLOT_W] = fields[i];
        end
    endgenerate
endmodule

// File: rtl/hp_parser_chk.sv
// Protocol checker for hp_parser, attached by bind.
module hp_parser_chk
    import hp_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int PHV_W = 280
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eop,
    input logic             phv_valid,
    input logic             phv_ready,
    input logic [PHV_W-1:0] phv_data
);
    logic eop_pend;

    // Remember that an end chunk was accepted and its PHV not yet taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eop_pend <= 1'b0;
        else if (phv_valid && phv_ready)
            eop_pend <= 1'b0;
        else if (in_valid && in_ready && in_eop)
            eop_pend <= 1'b1;
    end

    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid |-> !in_ready);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && !phv_ready |=> phv_valid && $stable(phv_data));
    p_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid |-> eop_pend);
    p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid |-> phv_data[LEN_W-1:0] != '0);
    p_root_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && phv_data[LEN_W +: N_ST] != '0 |-> phv_data[LEN_W]);
endmodule

bind hp_parser hp_parser_chk #(.LEN_W(LEN_W), .PHV_W(PHV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_eop(in_eop), .phv_valid(phv_valid), .phv_ready(phv_ready),
    .phv_data(phv_data)
);

// File: tb/hp_parser_test.sv
module hp_parser_test;
    import hp_pkg::*;
    localparam int CB = 8, WIN = 64, NF = 8, LW = 16;
    localparam int PW = NF * SLOT_W + N_ST + LW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, in_valid, in_ready, in_sop, in_eop, cfg_we, cfg_tbl, phv_valid, phv_ready;
    logic [63:0] in_data;
    logic [3:0] in_nbytes;
    logic [2:0] cfg_addr;
    logic [NODE_W-1:0] cfg_wdata;
    logic [PW-1:0] phv_data;

    hp_parser uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_nbytes(in_nbytes),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .phv_valid(phv_valid), .phv_ready(phv_ready), .phv_data(phv_data)
    );

    int checks = 0, fails = 0;
    logic [7:0] pkt [0:255];
    int plen;
    int g_hlen [N_ST], g_koff [N_ST];
    logic [19:0] g_pair [N_ST][N_PAIR];
    logic f_en [NF];
    int f_st [NF], f_off [NF];
    logic [N_ST-1:0] e_pres;
    logic [31:0] e_fld [NF];
    int e_len;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected PHV contents from the requirements (R3, R4, R5, R6).
    function automatic void model_walk();
        int st = 0, off = 0;
        e_pres = '0;
        for (int i = 0; i < NF; i++) e_fld[i] = '0;
        e_len = plen;
        for (int it = 0; it < 64; it++) begin
            int hl = g_hlen[st];
            int k  = g_koff[st];
            logic found = 1'b0;
            int nx = 0;
            logic [15:0] key;
            if (hl == 0 || off + hl > WIN || off + hl > plen) break;
            e_pres[st] = 1'b1;
            for (int i = 0; i < NF; i++)
                if (f_en[i] && f_st[i] == st)
                    e_fld[i] = {pkt[off+f_off[i]], pkt[off+f_off[i]+1], pkt[off+f_off[i]+2], pkt[off+f_off[i]+3]};
            key = {pkt[off+k], pkt[off+k+1]};
            for (int p = N_PAIR-1; p >= 0; p--)
                if (g_pair[st][p][19] && g_pair[st][p][15:0] == key) begin
                    found = 1'b1;
                    nx = int'(g_pair[st][p][18:16]);
                end
            if (!found) break;
            st = nx;
            off += hl;
        end
    endfunction

    // R10 graph write, mirrored into the model.
    task automatic wr_node(input int st, input int hl, input int ko,
                           input logic [19:0] p0, input logic [19:0] p1,
                           input logic [19:0] p2, input logic [19:0] p3);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = 0; cfg_addr = 3'(st);
        cfg_wdata = {6'(hl), 6'(ko), p3, p2, p1, p0};
        g_hlen[st] = hl; g_koff[st] = ko;
        g_pair[st][0] = p0; g_pair[st][1] = p1; g_pair[st][2] = p2; g_pair[st][3] = p3;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // R10 field descriptor write, mirrored into the model.
    task automatic wr_fld(input int idx, input logic en, input int st, input int off);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = 1; cfg_addr = 3'(idx);
        cfg_wdata = '0;
        cfg_wdata[9:0] = {en, 3'(st), 6'(off)};
        f_en[idx] = en; f_st[idx] = st; f_off[idx] = off;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic fill(input int n);
        plen = n;
        for (int i = 0; i < 256; i++) pkt[i] = 8'($urandom);
    endtask

    // Drive the packet as chunks, with random idle gaps (R2).
    task automatic send_pkt(input int gap_max);
        for (int c = 0; c * CB < plen; c++) begin
            logic [63:0] d;
            int nb;
            repeat ($urandom_range(0, gap_max)) begin
                @(negedge clk);
                in_valid = 0;
            end
            @(negedge clk);
            for (int b = 0; b < CB; b++)
                d[(CB-1-b)*8 +: 8] = (c*CB + b < plen) ? pkt[c*CB + b] : 8'($urandom);
            nb = plen - c * CB;
            in_data = d;
            in_sop = (c == 0);
            in_eop = ((c + 1) * CB >= plen);
            in_nbytes = (nb >= CB) ? 4'(($urandom_range(0, 1) == 0) ? 0 : 8) : 4'(nb);
            in_valid = 1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    // Wait for the PHV, stall it while a start chunk is offered, compare.
    task automatic recv_check(input string tag);
        int n = 0;
        logic [PW-1:0] held;
        while (!phv_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R7", {tag, " phv_valid after end"}, 64'(phv_valid), 64'd1);
        held = phv_data;
        in_data = 64'($urandom); in_sop = 1; in_eop = 1; in_nbytes = 4'd3; in_valid = 1;
        repeat ($urandom_range(1, 4)) @(negedge clk);
        chk("R8", {tag, " in_ready while PHV pending"}, 64'(in_ready), 64'd0);
        chk("R7", {tag, " PHV stable under stall"}, 64'(held == phv_data), 64'd1);
        chk("R6", {tag, " length slot"}, 64'(phv_data[LW-1:0]), 64'(e_len));
        chk("R5", {tag, " present bitmap"}, 64'(phv_data[LW +: N_ST]), 64'(e_pres));
        for (int i = 0; i < NF; i++)
            chk("R4", {tag, " field slot"}, 64'(phv_data[LW + N_ST + 32*i +: 32]), 64'(e_fld[i]));
        phv_ready = 1;
        @(negedge clk);
        phv_ready = 0;
        in_valid = 0;
        chk("R7", {tag, " phv_valid drops after take"}, 64'(phv_valid), 64'd0);
    endtask

    task automatic run_pkt(input string tag, input int gap_max);
        model_walk();
        send_pkt(gap_max);
        recv_check(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1badcafe));
        rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0; in_nbytes = '0;
        cfg_we = 0; cfg_tbl = 0; cfg_addr = '0; cfg_wdata = '0; phv_ready = 0;
        for (int s = 0; s < N_ST; s++) begin
            g_hlen[s] = 0; g_koff[s] = 0;
            for (int p = 0; p < N_PAIR; p++) g_pair[s][p] = '0;
        end
        for (int i = 0; i < NF; i++) begin f_en[i] = 0; f_st[i] = 0; f_off[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);
        chk("R1", "phv_valid after reset", 64'(phv_valid), 64'd0);

        // R11 / R1: empty graph gives length only.
        fill(20);
        run_pkt("R11 empty table", 0);

        // R10: program the graph; pair 3 of state 0 duplicates 0x0800 (R3 priority).
        wr_node(0, 14, 12, {1'b1,3'd1,16'h8100}, {1'b1,3'd2,16'h0800}, {1'b1,3'd3,16'h86DD}, {1'b1,3'd5,16'h0800});
        wr_node(1, 4, 2, {1'b1,3'd1,16'h8100}, {1'b1,3'd2,16'h0800}, 20'h0, 20'h0);
        wr_node(2, 20, 8, {1'b1,3'd4,16'h4006}, 20'h0, 20'h0, 20'h0);
        wr_node(3, 40, 0, 20'h0, 20'h0, 20'h0, 20'h0);
        wr_node(4, 20, 0, 20'h0, 20'h0, 20'h0, 20'h0);
        wr_node(5, 8, 0, 20'h0, 20'h0, 20'h0, 20'h0);
        wr_fld(0, 1, 0, 0);  wr_fld(1, 1, 0, 8);  wr_fld(2, 1, 1, 0);  wr_fld(3, 1, 2, 12);
        wr_fld(4, 1, 2, 16); wr_fld(5, 1, 4, 0);  wr_fld(6, 1, 3, 36); wr_fld(7, 0, 0, 0);

        // R2: a chunk with no open packet is dropped.
        @(negedge clk);
        in_data = 64'hdeadbeef_01020304; in_sop = 0; in_eop = 1; in_nbytes = 4'd3; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        repeat (4) @(negedge clk);
        chk("R2", "no PHV from stray chunk", 64'(phv_valid), 64'd0);
        chk("R2", "input open after stray chunk", 64'(in_ready), 64'd1);

        // R5 / R6: single short chunk, Ethernet cut off.
        fill(6);
        run_pkt("R5 short single chunk", 0);

        // R3: 0x0800 must pick pair 1 (state 2), not pair 3; exact-length end.
        fill(34);
        pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[22] = 8'h11; pkt[23] = 8'h00;
        run_pkt("R3 priority exact end", 0);

        // R5: IPv4 header cut by end of packet.
        fill(30);
        pkt[12] = 8'h08; pkt[13] = 8'h00;
        run_pkt("R5 truncated", 1);

        // R5: tag stack runs past the 64-byte window.
        fill(100);
        pkt[12] = 8'h81; pkt[13] = 8'h00;
        for (int k = 0; k < 16; k++) begin pkt[16+4*k] = 8'h81; pkt[17+4*k] = 8'h00; end
        run_pkt("R5 window limit", 0);

        // R9: headers straddling chunk boundaries, filled to byte 64.
        fill(64);
        pkt[12] = 8'h81; pkt[13] = 8'h00; pkt[16] = 8'h08; pkt[17] = 8'h00;
        pkt[26] = 8'h40; pkt[27] = 8'h06;
        run_pkt("R9 straddle", 2);

        // Random mix (R2, R3, R4, R5, R9).
        for (int n = 0; n < 80; n++) begin
            int sel, tags, base;
            fill($urandom_range(1, 120));
            sel = $urandom_range(0, 3);
            base = 14;
            case (sel)
                0: begin pkt[12] = 8'h08; pkt[13] = 8'h00; end
                1: begin
                    pkt[12] = 8'h81; pkt[13] = 8'h00;
                    tags = ($urandom_range(0, 4) == 0) ? 14 : $urandom_range(1, 3);
                    for (int k = 0; k < tags; k++) begin
                        pkt[16+4*k] = 8'h81; pkt[17+4*k] = 8'h00;
                    end
                    pkt[16+4*(tags-1)] = 8'h08; pkt[17+4*(tags-1)] = 8'h00;
                    base = 14 + 4 * tags;
                end
                2: begin pkt[12] = 8'h86; pkt[13] = 8'hDD; end
                default: ;
            endcase
            if ($urandom_range(0, 1) == 1) begin pkt[base+8] = 8'h40; pkt[base+9] = 8'h06; end
            run_pkt("R9 random", 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule